// File: doc/BRIEF.md
# Packet Filter Result Queue

This block turns the per-packet outcome of an address filter into a 16-bit result word. Each packet gives a source port ID, an address class, a lookup-hit flag and the port ID that the lookup returned. The block packs these into one word, holds up to eight words in arrival order, and offers the oldest word on a parallel result bus. A downstream consumer takes words from that bus with a select and a next strobe. A processor can drain the same queue through its own read strobe and data bus.

The input side is a plain valid strobe with no ready. The filter cannot stall a packet in flight, so a result that arrives when all eight slots are taken is dropped. A one-cycle overflow pulse reports each drop. On the output side, `rp_dv` is the valid signal and `rp_sel && rp_nxt` is the ready. A word is consumed on a clock edge only when valid and ready are both high. The processor strobe `cpu_rd` is a second ready on the same head entry. The two readers never consume more than one entry per cycle between them.

Top module: `rq_result_queue`

## Requirements
- R1: Bits 15:10 of every result word carry the 6-bit source port ID.
- R2: Bits 9:8 carry the address class code: broadcast 00, multicast 01, unicast 10.
- R3: Bit 7 is 1 only when the class is unicast (10) and the lookup hit. It is 0 for every other combination, including a hit reported on a broadcast or multicast packet.
- R4: Bits 6:1 carry the destination port ID when bit 7 is 1, and are 0 otherwise.
- R5: Bit 0 is 1 only when bit 7 is 1 and the destination port ID equals the source port ID.
- R6: `rp_dv` is high whenever at least one word is queued. A result accepted at a clock edge is visible right after that edge. `rp_dv` falls right after the edge that removes the last word.
- R7: The port advances only on an edge where `rp_sel` and `rp_nxt` are both high. `rp_nxt` alone, or `rp_sel` alone, leaves the queue unchanged.
- R8: `rp_data` shows the oldest queued word while `rp_sel` is high and a word is queued. Otherwise it reads zero.
- R9: `cpu_rdata` always shows the oldest queued word, or zero when the queue is empty. A `cpu_rd` edge removes that word. A `cpu_rd` edge on an empty queue has no effect.
- R10: An edge where the port advance and `cpu_rd` are both requested removes exactly one word.
- R11: The queue holds 8 words. A result offered while 8 words are queued and nothing is removed at that edge is dropped. For each drop, `ovf` is high for the one cycle after that edge. When a word is removed at the same edge, the new result is accepted.
- R12: Words leave in the order they were accepted, whichever read path removes them.
- R13: After a synchronous reset (`rst_n` low at a clock edge) the queue is empty, `rp_dv` and `ovf` are low, and both data buses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_valid | input | 1 | One result offered this cycle |
| res_src | input | 6 | Source port ID |
| res_class | input | 2 | Address class code |
| res_hit | input | 1 | Lookup found a match |
| res_dst | input | 6 | Port ID from the lookup |
| rp_sel | input | 1 | Result bus select |
| rp_nxt | input | 1 | Advance request, gated by rp_sel |
| rp_dv | output | 1 | At least one word queued |
| rp_data | output | 16 | Oldest word while selected, else zero |
| cpu_rd | input | 1 | Processor read-and-remove strobe |
| cpu_rdata | output | 16 | Oldest word, or zero when empty |
| ovf | output | 1 | One-cycle pulse: a result was dropped |

## Verification
The bench compares every cycle against a behavioural model. It attacks the conditional fields with a hit reported on a multicast packet and on a broadcast packet, with a unicast miss, and with a same-port hit. A packer that does not gate these fields would leak a destination ID or a same-port flag into those words. It holds `rp_nxt` high without `rp_sel` to catch an ungated advance, and it fires both read paths in one cycle to catch a double pop that would silently lose a word. It also overfills the queue, then offers a result while full and popping. A design with the wrong full test would either overwrite the head or refuse a slot that is being freed.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    CLS_BCAST = 2'b00,
    CLS_MCAST = 2'b01,
    CLS_UCAST = 2'b10,
    CLS_RSVD  = 2'b11
  } rq_class_e;
endpackage

// File: rtl/rq_word_pack.sv
module rq_word_pack #(
  parameter int ID_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   src,
  input  logic [1:0]        cls,
  input  logic              hit,
  input  logic [ID_W-1:0]   dst,
  output logic [2*ID_W+3:0] word
);
  import rq_pkg::*;
  localparam int WW = 2*ID_W + 4;

  logic            is_ucast;
  logic            match;
  logic [ID_W-1:0] dst_field;
  logic            same_port;

  always_comb begin
    is_ucast  = (cls == CLS_UCAST);
    match     = is_ucast && hit;
    dst_field = match ? dst : '0;
    same_port = match && (dst == src);
    word      = {src, cls, match, dst_field, same_port};
  end

  AST_NONUCAST_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (cls != CLS_UCAST) |-> (word[ID_W+1:0] == '0)); // R3
  AST_MISS_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (word[ID_W+1:0] == '0)); // R4
  AST_SELF_IMPLIES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    word[0] |-> word[ID_W+1]); // R5
endmodule

// File: rtl/rq_fifo.sv
module rq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] wr_ptr;
  logic [CW-1:0] count;
  logic          pop_ok;
  logic          push_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    empty   = (count == '0);
    full    = (count == CW'(DEPTH));
    pop_ok  = pop && !empty;
    push_ok = push && (!full || pop_ok);
    dout    = empty ? '0 : mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      drop   <= 1'b0;
    end else begin
      drop <= push && !push_ok;
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      if (push_ok) wr_ptr <= bump(wr_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_DV_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && empty) |=> !empty); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R11
  AST_DROP_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> drop); // R11
  AST_HOLD_WITHOUT_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> (int'(count) >= int'($past(count)))); // R7
  AST_SINGLE_REMOVAL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(count) + 1 >= int'($past(count)))); // R10
endmodule

// File: rtl/rq_port_ctl.sv
module rq_port_ctl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         nxt,
  input  logic         cpu_rd,
  input  logic         empty,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic         dv,
  output logic [W-1:0] bus_data,
  output logic [W-1:0] cpu_data
);
  logic port_adv;

  always_comb begin
    port_adv = sel && nxt;
    pop      = port_adv || cpu_rd;
    dv       = !empty;
    bus_data = (sel && !empty) ? head : '0;
    cpu_data = empty ? '0 : head;
  end

  AST_BUS_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !dv |-> (bus_data == '0 && cpu_data == '0)); // R8
  AST_HEAD_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && !pop) |=> $stable(cpu_data)); // R7
endmodule

// File: rtl/rq_result_queue.sv
module rq_result_queue #(
  parameter int ID_W  = 6,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [ID_W-1:0]   res_src,
  input  logic [1:0]        res_class,
  input  logic              res_hit,
  input  logic [ID_W-1:0]   res_dst,
  input  logic              rp_sel,
  input  logic              rp_nxt,
  output logic              rp_dv,
  output logic [2*ID_W+3:0] rp_data,
  input  logic              cpu_rd,
  output logic [2*ID_W+3:0] cpu_rdata,
  output logic              ovf
);
  localparam int WW = 2*ID_W + 4;

  logic [WW-1:0] packed_word;
  logic [WW-1:0] head;
  logic          empty;
  logic          full;
  logic          pop;

  rq_word_pack #(.ID_W(ID_W)) u_pack (
    .clk  (clk),
    .rst_n(rst_n),
    .src  (res_src),
    .cls  (res_class),
    .hit  (res_hit),
    .dst  (res_dst),
    .word (packed_word)
  );

  rq_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (res_valid),
    .din  (packed_word),
    .pop  (pop),
    .dout (head),
    .empty(empty),
    .full (full),
    .drop (ovf)
  );

  rq_port_ctl #(.W(WW)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (rp_sel),
    .nxt     (rp_nxt),
    .cpu_rd  (cpu_rd),
    .empty   (empty),
    .head    (head),
    .pop     (pop),
    .dv      (rp_dv),
    .bus_data(rp_data),
    .cpu_data(cpu_rdata)
  );

  AST_DV_FALLS_ONLY_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_dv && !rp_sel && !cpu_rd) |=> rp_dv); // R6
endmodule

// File: tb/rq_result_queue_tb.sv
`timescale 1ns/1ps
module rq_result_queue_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid;
  logic [5:0]  res_src;
  logic [1:0]  res_class;
  logic        res_hit;
  logic [5:0]  res_dst;
  logic        rp_sel;
  logic        rp_nxt;
  logic        rp_dv;
  logic [15:0] rp_data;
  logic        cpu_rd;
  logic [15:0] cpu_rdata;
  logic        ovf;

  int tests  = 0;
  int fails  = 0;
  string cur_tag = "R12";

  logic [15:0] q[$];
  logic        ovf_e = 1'b0;

  always #4 clk = ~clk;

  rq_result_queue dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_src(res_src),
    .res_class(res_class), .res_hit(res_hit), .res_dst(res_dst),
    .rp_sel(rp_sel), .rp_nxt(rp_nxt), .rp_dv(rp_dv), .rp_data(rp_data),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .ovf(ovf)
  );

  function automatic logic [15:0] exp_word(input logic [5:0] s, input logic [1:0] c,
                                           input logic h, input logic [5:0] d);
    logic m;
    m = (c == 2'b10) && h;
    return {s, c, m, (m ? d : 6'd0), (m && d == s)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic        popped;
    logic [15:0] head_e;
    @(posedge clk);
    if (!rst_n) begin
      q.delete();
      ovf_e = 1'b0;
    end else begin
      popped = ((rp_sel && rp_nxt) || cpu_rd) && (q.size() > 0);
      if (popped) void'(q.pop_front());
      ovf_e = 1'b0;
      if (res_valid) begin
        if (q.size() < DEPTH) q.push_back(exp_word(res_src, res_class, res_hit, res_dst));
        else ovf_e = 1'b1;
      end
    end
    @(negedge clk);
    head_e = (q.size() > 0) ? q[0] : 16'h0;
    chk("R6 rp_dv", {15'd0, rp_dv}, {15'd0, q.size() > 0});
    chk("R11 ovf", {15'd0, ovf}, {15'd0, ovf_e});
    chk("R9 cpu_rdata", cpu_rdata, head_e);
    chk("R8 rp_data", rp_data, rp_sel ? head_e : 16'h0);
    chk(cur_tag, cpu_rdata, head_e);
    if (rp_sel && q.size() > 0) begin
      chk("R1 src field", {10'd0, rp_data[15:10]}, {10'd0, head_e[15:10]});
      chk("R2 class field", {14'd0, rp_data[9:8]}, {14'd0, head_e[9:8]});
      chk("R3 match bit", {15'd0, rp_data[7]}, {15'd0, head_e[7]});
      chk("R4 dest field", {10'd0, rp_data[6:1]}, {10'd0, head_e[6:1]});
      chk("R5 same-port bit", {15'd0, rp_data[0]}, {15'd0, head_e[0]});
    end
  endtask

  task automatic idle_inputs();
    res_valid = 0; res_src = 0; res_class = 0; res_hit = 0; res_dst = 0;
    rp_nxt = 0; cpu_rd = 0;
  endtask

  task automatic push(input logic [5:0] s, input logic [1:0] c,
                      input logic h, input logic [5:0] d);
    res_valid = 1; res_src = s; res_class = c; res_hit = h; res_dst = d;
    step();
    res_valid = 0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rp_sel = 0; idle_inputs();
    cur_tag = "R13";
    step(); step();
    rst_n = 1;
    step();
    chk("R13 reset dv", {15'd0, rp_dv}, 16'd0);
    chk("R13 reset bus", rp_data | cpu_rdata, 16'd0);

    cur_tag = "R12";
    push(6'd3, 2'b00, 0, 6'd0);
    push(6'd5, 2'b01, 1, 6'd9);
    push(6'd7, 2'b10, 0, 6'd33);
    push(6'd10, 2'b10, 1, 6'd20);
    push(6'd12, 2'b10, 1, 6'd12);
    push(6'd63, 2'b00, 1, 6'd63);

    cur_tag = "R7";
    rp_nxt = 1;
    repeat (3) step();
    rp_nxt = 0; rp_sel = 1;
    repeat (2) step();

    cur_tag = "R12";
    rp_nxt = 1;
    repeat (3) step();
    rp_nxt = 0;
    step();

    cur_tag = "R9";
    rp_sel = 0; cpu_rd = 1;
    step();
    cpu_rd = 0; rp_sel = 1;
    step();

    cur_tag = "R10";
    rp_nxt = 1; cpu_rd = 1;
    step();
    rp_nxt = 0;
    repeat (3) step();
    cpu_rd = 0;
    step();

    cur_tag = "R11";
    rp_sel = 0;
    for (int i = 0; i < 10; i++) push(6'(i + 20), 2'(i % 3), 1, 6'(i + 20));
    step();
    rp_sel = 1; rp_nxt = 1;
    push(6'd40, 2'b10, 1, 6'd41);
    rp_nxt = 0;
    push(6'd44, 2'b10, 0, 6'd1);
    cur_tag = "R12";
    rp_nxt = 1;
    repeat (10) step();
    idle_inputs();
    step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule